// File: doc/BRIEF.md
# Serial Register Port

A slave serial front end that sits between an external host and a bank of internal registers. The host first shifts in an 8-bit command byte, most significant bit first. The byte names a register and says whether to write it once, read it once, or read it over and over. The port then moves a word of 8, 16 or 24 bits, MSB first, between the serial pins and a simple parallel register bus. The port learns the word length from a size code that the register bank returns for the selected register.

The serial clock is oversampled by the system clock. A polarity input chooses which serial clock edge samples input data and which edge launches output data. An active-low chip select gates every serial edge. A run of 32 ones on the data input puts the port back into command wait and pulses a reset for the rest of the part. In continuous-read mode the port keeps reading the same register with no command in between. It still samples the data input, and it leaves the mode when the last eight bits of a word form the exit code 0x30.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, dout_o, reg_wr_o and soft_rst_o are 0, and the port waits for a command byte.
- R2: A command byte starts with a 0 bit. Any 1 sampled at the first bit position is skipped, and the port keeps waiting at that position. The byte fields are: bit 7 write-enable-low, bits 5:4 mode, bits 2:0 register select.
- R3: Mode 00 writes one word. Its bits are taken MSB first and sent out right-aligned on reg_wdata_o with reg_sel_o, together with one single-cycle reg_wr_o pulse after the last bit. The port then waits for a command.
- R4: Mode 01 reads one word of the selected register. Its bits go out MSB first on dout_o, and the port then waits for a command.
- R5: The word length follows reg_size_i for the selected register: code 0 gives 8 bits, code 1 gives 16 bits, and codes 2 and 3 give 24 bits.
- R6: Mode 10 reads the selected register word after word with no command in between. The port leaves this mode at a word end only when the last eight data-input bits sampled in that word equal 0x30.
- R7: These bytes perform no transfer and strobe nothing, and the following byte is taken as a new command: a mode-11 byte received while waiting for a command (such as 0x30), and a command with bit 6 or bit 3 set.
- R8: The 32nd consecutive sampled 1 on din_i gives one soft_rst_o pulse and returns the port to command wait, with no write strobe on that edge. The count runs across transfer boundaries, and 31 ones give no pulse.
- R9: With pol_i = 0, input is sampled on the falling serial clock edge and output changes on the rising edge. With pol_i = 1 the two edges are swapped.
- R10: A write to select RO_SEL (default 1) clocks in the full word but raises no reg_wr_o, and the register keeps its value.
- R11: While cs_ni is high, serial edges are ignored and the bit counters hold. A transfer interrupted mid-word resumes when cs_ni goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data input |
| pol_i | input | 1 | Serial clock polarity select |
| dout_o | output | 1 | Serial data output |
| reg_sel_o | output | 3 | Register select from the last command |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 24 | Write data, right-aligned |
| reg_rdata_i | input | 24 | Read data of the selected register, right-aligned |
| reg_size_i | input | 2 | Size code of the selected register |
| soft_rst_o | output | 1 | One-cycle pulse after 32 ones |

## Verification
The bench builds the port with its default parameters: a reset run of 32 ones and read-only select 1. With these values it can step exactly to the 31st and 32nd one and tell them apart. It can also write to the read-only register and read the same register back. The bench's register bank returns size codes 0, 1, 2 and 3 on different selects, and it switches the length of the read-only register between 16 and 24 bits, so every word length and both length encodings for 24 bits are covered. The bench moves din_i between the launch edge and the sample edge, so sampling on the wrong edge shows up under both polarities.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MID_W  = 16;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned SEL_W  = 3;
  localparam logic [BYTE_W-1:0] CRD_EXIT = 8'h30;

  typedef enum logic [1:0] {MD_WRITE = 2'b00, MD_READ = 2'b01, MD_CONT = 2'b10, MD_STOP = 2'b11} mode_e;
  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_CRD} state_e;

  typedef struct packed {
    logic             wen_n;
    logic             rsv6;
    mode_e            mode;
    logic             rsv3;
    logic [SEL_W-1:0] sel;
  } cmd_t;

  function automatic logic [BIT_W-1:0] last_bit(logic [1:0] sz);
    case (sz)
      2'd0:    return BIT_W'(BYTE_W - 1);
      2'd1:    return BIT_W'(MID_W - 1);
      default: return BIT_W'(WORD_W - 1);
    endcase
  endfunction
endpackage

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic pol_i,
  output logic sample_o,
  output logic launch_o
);
  logic sclk_q, arm_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      arm_q  <= 1'b1;
    end
  end

  // arm_q masks the false edge right after reset when the clock idles high
  assign rise     = arm_q & sclk_i & ~sclk_q;
  assign fall     = arm_q & ~sclk_i & sclk_q;
  assign sample_o = ~cs_ni & (pol_i ? rise : fall);
  assign launch_o = ~cs_ni & (pol_i ? fall : rise);
endmodule

// File: rtl/srp_ones_det.sv
module srp_ones_det #(
  parameter int unsigned ONES_RST = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic din_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(ONES_RST + 1);
  logic [CW-1:0] cnt_q;

  assign hit_o = sample_i & din_i & (cnt_q == CW'(ONES_RST - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (sample_i) begin
      if (!din_i || hit_o)       cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srp_rd_shift.sv
module srp_rd_shift import serial_reg_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              dout_o
);
  logic [WORD_W-1:0] sr_q, aligned;

  always_comb begin
    case (size_i)
      2'd0:    aligned = {rdata_i[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
      2'd1:    aligned = {rdata_i[MID_W-1:0], {(WORD_W-MID_W){1'b0}}};
      default: aligned = rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_o <= 1'b0;
    end else begin
      if (clear_i) dout_o <= 1'b0;
      if (load_i) sr_q <= aligned;
      else if (shift_i) begin
        dout_o <= sr_q[WORD_W-1];
        sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port import serial_reg_pkg::*; #(
  parameter int unsigned ONES_RST = 32,
  parameter int unsigned RO_SEL   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  input  logic              pol_i,
  output logic              dout_o,
  output logic [SEL_W-1:0]  reg_sel_o,
  output logic              reg_wr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  input  logic [1:0]        reg_size_i,
  output logic              soft_rst_o
);
  state_e             state_q;
  logic [BIT_W-1:0]   bit_q;
  logic [BYTE_W-2:0]  cmd_q, mon_q;
  logic [WORD_W-2:0]  wacc_q;
  logic [SEL_W-1:0]   sel_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               ld_q, wstb_q, srst_q;
  logic               sample, launch, ones_hit;
  cmd_t               cmd_w;
  logic               cmd_ok, at_end, mon_exit, reload, rd_active;

  srp_edge i_edge (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .pol_i,
    .sample_o(sample), .launch_o(launch)
  );

  srp_ones_det #(.ONES_RST(ONES_RST)) i_ones (
    .clk_i, .rst_ni, .sample_i(sample), .din_i, .hit_o(ones_hit)
  );

  assign cmd_w     = cmd_t'({cmd_q, din_i});
  assign cmd_ok    = ~cmd_w.wen_n & ~cmd_w.rsv6 & ~cmd_w.rsv3;
  assign at_end    = (bit_q == last_bit(reg_size_i));
  assign mon_exit  = ({mon_q, din_i} == CRD_EXIT);
  assign rd_active = (state_q == ST_RD) || (state_q == ST_CRD);
  assign reload    = sample & ~ones_hit & (state_q == ST_CRD) & at_end & ~mon_exit;

  srp_rd_shift i_rd (
    .clk_i, .rst_ni,
    .clear_i(state_q == ST_CMD),
    .load_i (ld_q | reload),
    .shift_i(launch & rd_active),
    .size_i (reg_size_i),
    .rdata_i(reg_rdata_i),
    .dout_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      bit_q   <= '0;
      cmd_q   <= '0;
      mon_q   <= '0;
      wacc_q  <= '0;
      sel_q   <= '0;
      wdata_q <= '0;
      ld_q    <= 1'b0;
      wstb_q  <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      ld_q   <= 1'b0;
      wstb_q <= 1'b0;
      srst_q <= 1'b0;
      if (ones_hit) begin
        state_q <= ST_CMD;
        bit_q   <= '0;
        srst_q  <= 1'b1;
      end else if (sample) begin
        case (state_q)
          ST_CMD: begin
            // a 1 in the start position stalls the byte
            if (!(bit_q == '0 && din_i)) begin
              if (bit_q == BIT_W'(BYTE_W - 1)) begin
                bit_q <= '0;
                if (cmd_ok) begin
                  case (cmd_w.mode)
                    MD_WRITE: begin sel_q <= cmd_w.sel; wacc_q <= '0; state_q <= ST_WR; end
                    MD_READ:  begin sel_q <= cmd_w.sel; ld_q <= 1'b1; state_q <= ST_RD; end
                    MD_CONT:  begin sel_q <= cmd_w.sel; ld_q <= 1'b1; mon_q <= '0; state_q <= ST_CRD; end
                    default:  ;
                  endcase
                end
              end else begin
                cmd_q <= {cmd_q[BYTE_W-3:0], din_i};
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_WR: begin
            wacc_q <= {wacc_q[WORD_W-3:0], din_i};
            if (at_end) begin
              bit_q   <= '0;
              state_q <= ST_CMD;
              if (sel_q != SEL_W'(RO_SEL)) begin
                wstb_q  <= 1'b1;
                wdata_q <= {wacc_q, din_i};
              end
            end else bit_q <= bit_q + 1'b1;
          end
          ST_RD: begin
            if (at_end) begin
              bit_q   <= '0;
              state_q <= ST_CMD;
            end else bit_q <= bit_q + 1'b1;
          end
          ST_CRD: begin
            mon_q <= {mon_q[BYTE_W-3:0], din_i};
            if (at_end) begin
              bit_q <= '0;
              mon_q <= '0;
              if (mon_exit) state_q <= ST_CMD;
            end else bit_q <= bit_q + 1'b1;
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  assign reg_sel_o   = sel_q;
  assign reg_wr_o    = wstb_q;
  assign reg_wdata_o = wdata_q;
  assign soft_rst_o  = srst_q;
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned RO_SEL = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [2:0] reg_sel_o,
  input logic       reg_wr_o,
  input logic       soft_rst_o
);
  p_wr_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  p_ro_guard_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_sel_o != 3'(RO_SEL)));

  p_srst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  p_srst_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !reg_wr_o);

  p_cs_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !reg_wr_o);

  p_cs_srst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !soft_rst_o);
endmodule

bind serial_reg_port srp_checker #(.RO_SEL(RO_SEL)) i_srp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .reg_sel_o(reg_sel_o),
  .reg_wr_o(reg_wr_o), .soft_rst_o(soft_rst_o)
);

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, cs_ni = 1'b1, din_i = 1'b0, pol_i = 1'b0;
  logic        dout_o, reg_wr_o, soft_rst_o;
  logic [2:0]  reg_sel_o;
  logic [23:0] reg_wdata_o, reg_rdata_i;
  logic [1:0]  reg_size_i;
  logic        dl24 = 1'b1;
  logic [23:0] bank [8];
  logic [26:0] exp_q [$];
  int          n_chk = 0, n_err = 0, srst_cnt = 0;
  logic        done = 1'b0;

  always #10 clk_i = ~clk_i;

  serial_reg_port i_serial_reg_port (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i, .pol_i, .dout_o,
    .reg_sel_o, .reg_wr_o, .reg_wdata_o, .reg_rdata_i, .reg_size_i, .soft_rst_o
  );

  // register bank model
  always_comb begin
    case (reg_sel_o)
      3'd0:    reg_size_i = 2'd0;
      3'd1:    reg_size_i = dl24 ? 2'd2 : 2'd1;
      3'd2:    reg_size_i = 2'd1;
      3'd7:    reg_size_i = 2'd3;
      default: reg_size_i = 2'd2;
    endcase
  end
  assign reg_rdata_i = bank[reg_sel_o];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) bank[i] <= 24'h0;
      bank[1] <= 24'hA5C3E7;
    end else if (reg_wr_o) bank[reg_sel_o] <= reg_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes and soft reset pulses
  always @(negedge clk_i) begin
    if (rst_ni && reg_wr_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", {21'b0, reg_sel_o}, 24'h0);
      else begin
        logic [26:0] e;
        e = exp_q.pop_front();
        chk(reg_sel_o == e[26:24], "R3 strobe select", {21'b0, reg_sel_o}, {21'b0, e[26:24]});
        chk(reg_wdata_o == e[23:0], "R3 strobe data", reg_wdata_o, e[23:0]);
      end
    end
    if (rst_ni && soft_rst_o) srst_cnt++;
  end

  task automatic bitx(input logic d, output logic q);
    @(negedge clk_i); din_i = ~d;
    repeat (3) @(negedge clk_i);
    sclk_i = ~pol_i;                       // launch edge
    repeat (2) @(negedge clk_i);
    din_i = d;
    @(negedge clk_i); q = dout_o;
    @(negedge clk_i); sclk_i = pol_i;      // sample edge
    repeat (3) @(negedge clk_i);
  endtask

  task automatic word(input int n, input logic [23:0] w, output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitx(w[i], b);
      r = {r[22:0], b};
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [23:0] dmy;
    word(8, {16'h0, c}, dmy);
  endtask

  task automatic wr(input logic [2:0] sel, input int n, input logic [23:0] d, input bit strobe);
    logic [23:0] dmy;
    if (strobe) exp_q.push_back({sel, d});
    cmd({5'b00000, sel});
    word(n, d, dmy);
  endtask

  task automatic rd(input logic [2:0] sel, input int n, input logic [23:0] exp, input string req);
    logic [23:0] r;
    cmd({5'b00010, sel});
    word(n, 24'h0, r);
    chk(r == exp, req, r, exp);
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk_i); sclk_i = p;
    repeat (3) @(negedge clk_i);
    pol_i = p;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 24'h0, 24'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    logic        dmy;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(dout_o == 1'b0, "R1 dout", {23'b0, dout_o}, 24'h0);
    chk(reg_wr_o == 1'b0, "R1 strobe", {23'b0, reg_wr_o}, 24'h0);
    chk(soft_rst_o == 1'b0, "R1 soft reset", {23'b0, soft_rst_o}, 24'h0);
    cs_ni = 1'b0;
    repeat (2) @(negedge clk_i);

    // R3 R5 R9 write 16-bit register, pol 0
    wr(3'd2, 16, 24'h00BEEF, 1'b1);
    // R2 leading ones before the start bit
    bitx(1'b1, dmy); bitx(1'b1, dmy); bitx(1'b1, dmy);
    wr(3'd0, 8, 24'h00005A, 1'b1);
    // R4 R5 R9 reads
    rd(3'd2, 16, 24'h00BEEF, "R4 read 16-bit");
    rd(3'd0, 8, 24'h00005A, "R4 read 8-bit");
    // R10 write to read-only register, no strobe
    wr(3'd1, 24, 24'h123456, 1'b0);
    rd(3'd1, 24, 24'hA5C3E7, "R10 read-only kept");
    // R5 24-bit with code 2 and code 3
    wr(3'd3, 24, 24'hC0FFEE, 1'b1);
    rd(3'd3, 24, 24'hC0FFEE, "R5 24-bit code 2");
    wr(3'd7, 24, 24'h0F0F0E, 1'b1);
    rd(3'd7, 24, 24'h0F0F0E, "R5 24-bit code 3");
    dl24 = 1'b0;
    rd(3'd1, 16, 24'h00C3E7, "R5 16-bit data word");
    dl24 = 1'b1;
    // R7 no-op bytes
    cmd(8'h30);
    rd(3'd0, 8, 24'h00005A, "R7 after stop byte");
    cmd(8'h4A);
    cmd(8'h0A);
    rd(3'd0, 8, 24'h00005A, "R7 after reserved-bit commands");
    // R6 continuous read
    cmd(8'h22);
    word(16, 24'h000000, r); chk(r == 24'h00BEEF, "R6 word 1", r, 24'h00BEEF);
    word(16, 24'h003000, r); chk(r == 24'h00BEEF, "R6 word 2 no exit", r, 24'h00BEEF);
    word(16, 24'h000030, r); chk(r == 24'h00BEEF, "R6 word 3 exit", r, 24'h00BEEF);
    rd(3'd0, 8, 24'h00005A, "R6 command after exit");

    // R9 polarity 1
    set_pol(1'b1);
    wr(3'd0, 8, 24'h0000C3, 1'b1);
    rd(3'd0, 8, 24'h0000C3, "R9 pol 1 read back");

    // R11 chip select pause mid-word
    exp_q.push_back({3'd2, 24'h001234});
    cmd(8'h02);
    for (int i = 15; i >= 11; i--) bitx(1'(16'h1234 >> i), dmy);
    @(negedge clk_i); cs_ni = 1'b1; din_i = 1'b1;
    repeat (6) begin
      repeat (4) @(negedge clk_i); sclk_i = ~pol_i;
      repeat (4) @(negedge clk_i); sclk_i = pol_i;
    end
    repeat (4) @(negedge clk_i); cs_ni = 1'b0;
    for (int i = 10; i >= 0; i--) bitx(1'(16'h1234 >> i), dmy);
    rd(3'd2, 16, 24'h001234, "R11 resumed write");
    chk(srst_cnt == 0, "R11 no soft reset while deselected", 24'(srst_cnt), 24'h0);

    // R8 ones reset boundary
    for (int i = 0; i < 31; i++) bitx(1'b1, dmy);
    chk(srst_cnt == 0, "R8 31 ones", 24'(srst_cnt), 24'h0);
    bitx(1'b1, dmy);
    repeat (2) @(negedge clk_i);
    chk(srst_cnt == 1, "R8 32 ones", 24'(srst_cnt), 24'h1);
    wr(3'd0, 8, 24'h0000FF, 1'b1);
    word(24, 24'hFFFFFF, r);
    repeat (2) @(negedge clk_i);
    chk(srst_cnt == 2, "R8 ones across transfer", 24'(srst_cnt), 24'h2);
    rd(3'd0, 8, 24'h0000FF, "R8 command after soft reset");

    repeat (10) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 all strobes seen", 24'(exp_q.size()), 24'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule